// File: doc/BRIEF.md
# Processor Trap Priority Controller

This block sits beside a 16-bit processor core and manages traps. Traps are error events that cannot be masked. Error detectors raise request lines, one line per trap. Each line carries a fixed priority level, and the eight levels run from 8 to 15, above every maskable interrupt level. The block holds requests until the faulting instruction has finished. It then selects the most urgent pending trap and reports the vector index of that trap. While the handler runs, the block drives the processor's 4-bit priority field to the trap's level.

Traps nest. A pending trap whose level is above the running level preempts the running handler. The priority value that was in force before the trap goes onto an internal stack. A handler-return strobe pops the stack and restores that value. When two or more request lines rise in the same cycle, the block takes no trap. It emits a one-cycle lockout reset pulse and returns to its reset state.

Top module: `trap_prio_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `trap_take`, `vec_idx`, `pri_out`, `trap_active` and `lockout_rst` are all zero.
- R2: A request on `trap_req[i]` (trap level 8+i) is recorded. It stays pending, whatever `insn_done` does, until that trap is taken or a lockout happens.
- R3: A trap is taken only in a cycle where `insn_done` is 1. One cycle later, `trap_take` pulses for one cycle and `vec_idx` equals i, the bit number of the highest pending request.
- R4: When no trap is active, a pending trap is taken whatever the value of `cur_pri` is. This includes 7 (`0111`) and 15.
- R5: While a trap is active, a pending trap is taken only if its level 8+i is strictly greater than `pri_out`. Lower or equal requests stay pending.
- R6: When a trap is taken, `pri_out` becomes 8+i and `trap_active` becomes 1. Bit 3 of `pri_out` is 1 in every cycle that `trap_active` is 1.
- R7: If `handler_ret` is 1 while a trap is active, `pri_out` is restored one cycle later to the value it had before the latest trap entry. In that cycle the return blocks any trap entry. If no trap is active, `handler_ret` has no effect.
- R8: While no trap is active, `pri_out` equals the `cur_pri` value of the previous cycle.
- R9: If two or more bits of `trap_req` are 1 in one cycle, then in the next cycle `lockout_rst` is 1, `trap_take` is 0, `trap_active` is 0 and `pri_out` is 0. All pending requests are also discarded. The pulse lasts one cycle unless the condition repeats.
- R10: Traps nest up to eight deep (levels 8 through 15). Eight returns unwind the nesting back to the original priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 8 | Trap request lines; bit i is level 8+i |
| cur_pri | input | 4 | Processor priority field as written by software |
| insn_done | input | 1 | Current instruction completes this cycle |
| handler_ret | input | 1 | Trap handler returns this cycle |
| trap_take | output | 1 | One-cycle pulse: trap entry |
| vec_idx | output | 3 | Vector index of the last trap taken (level minus 8) |
| pri_out | output | 4 | Effective priority level |
| trap_active | output | 1 | At least one trap handler is running |
| lockout_rst | output | 1 | Lockout reset pulse |

## Verification
The main function is tried with requests held back until `insn_done` rises. Software priorities of 7 and 15 show that traps ignore the mask. Ascending levels exercise nesting to full depth, and descending levels show that a lower trap cannot preempt. Single-bit requests are compared with multi-bit ones, which separates arbitration from lockout. Returns in the same cycle as a take, and returns while idle, check the precedence and ignore rules. A seeded random mix of all of these runs against a bench-side model of the pending set and the priority stack.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned NTRAP = 8;
  localparam int unsigned PRI_W = 4;
  localparam int unsigned IDX_W = $clog2(NTRAP);

  // level of trap index: top bit of priority field set, index below it
  function automatic logic [PRI_W-1:0] f_level(input logic [IDX_W-1:0] idx);
    logic [PRI_W-1:0] lv;
    lv = '0;
    lv[PRI_W-1] = 1'b1;
    lv[IDX_W-1:0] = idx;
    return lv;
  endfunction

  function automatic logic [IDX_W-1:0] f_top_idx(input logic [NTRAP-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NTRAP; i++)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic f_many(input logic [NTRAP-1:0] v);
    int unsigned c;
    c = 0;
    for (int i = 0; i < NTRAP; i++)
      c += v[i] ? 1 : 0;
    return c >= 2;
  endfunction
endpackage

// File: rtl/trap_pick.sv
module trap_pick
  import trap_pkg::*;
#(
  parameter int unsigned N  = NTRAP,
  parameter int unsigned IW = IDX_W
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  req,
  output logic [IW-1:0] top_idx,
  output logic          has_pend,
  output logic          multi
);
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < N; i++)
      if (pend[i]) top_idx = IW'(i);
  end

  assign has_pend = |pend;

  // more than one request in the same cycle
  always_comb begin
    int unsigned cnt;
    cnt = 0;
    for (int i = 0; i < N; i++)
      cnt += req[i] ? 1 : 0;
    multi = (cnt >= 2);
  end
endmodule

// File: rtl/trap_pri_stack.sv
module trap_pri_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  top,
  output logic [DW-1:0] depth
);
  logic [W-1:0]  mem [DEPTH];
  logic [DW-1:0] dm1;

  assign dm1 = depth - DW'(1);
  assign top = (depth != '0) ? mem[dm1[AW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      depth <= '0;
    end else if (pop && depth != '0) begin
      depth <= dm1;
    end else if (push && depth != DW'(DEPTH)) begin
      depth <= depth + DW'(1);
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) mem[g] <= '0;
        else if (push && !pop && !clr && depth == DW'(g)) mem[g] <= din;
      end
    end
  endgenerate
endmodule

// File: rtl/trap_prio_ctrl.sv
module trap_prio_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned N_TRAPS = NTRAP,
  parameter int unsigned PW      = PRI_W,
  localparam int unsigned IW     = $clog2(N_TRAPS),
  localparam int unsigned DW     = $clog2(N_TRAPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N_TRAPS-1:0] trap_req,
  input  logic [PW-1:0] cur_pri,
  input  logic          insn_done,
  input  logic          handler_ret,
  output logic          trap_take,
  output logic [IW-1:0] vec_idx,
  output logic [PW-1:0] pri_out,
  output logic          trap_active,
  output logic          lockout_rst
);
  logic [N_TRAPS-1:0] pend_q;
  logic [PW-1:0]      pri_q;
  logic               take_q, lock_q;
  logic [IW-1:0]      vec_q;

  // named internal events
  logic [IW-1:0] cand_idx;
  logic          has_pend, multi_evt, ret_evt, take_evt;
  logic [PW-1:0] cand_lvl, stk_top;
  logic [DW-1:0] depth;
  logic [N_TRAPS-1:0] take_mask;

  trap_pick #(.N(N_TRAPS), .IW(IW)) u_pick (
    .pend    (pend_q),
    .req     (trap_req),
    .top_idx (cand_idx),
    .has_pend(has_pend),
    .multi   (multi_evt)
  );

  trap_pri_stack #(.DEPTH(N_TRAPS), .W(PW)) u_stk (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (multi_evt),
    .push (take_evt),
    .pop  (ret_evt),
    .din  (pri_q),
    .top  (stk_top),
    .depth(depth)
  );

  assign cand_lvl = PW'(N_TRAPS) + PW'(cand_idx);
  assign ret_evt  = handler_ret && (depth != '0) && !multi_evt;
  assign take_evt = has_pend && insn_done && !ret_evt && !multi_evt &&
                    ((depth == '0) || (cand_lvl > pri_q));

  always_comb begin
    take_mask = '0;
    if (take_evt) take_mask[cand_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || multi_evt) begin
      pend_q <= '0;
      pri_q  <= '0;
      take_q <= 1'b0;
      vec_q  <= '0;
      lock_q <= rst_n && multi_evt;
    end else begin
      lock_q <= 1'b0;
      take_q <= take_evt;
      pend_q <= (pend_q & ~take_mask) | trap_req;
      if (take_evt) vec_q <= cand_idx;
      if (ret_evt)          pri_q <= stk_top;
      else if (take_evt)    pri_q <= cand_lvl;
      else if (depth == '0) pri_q <= cur_pri;
    end
  end

  assign trap_take   = take_q;
  assign vec_idx     = vec_q;
  assign pri_out     = pri_q;
  assign trap_active = (depth != '0);
  assign lockout_rst = lock_q;
endmodule

// File: rtl/trap_prio_ctrl_chk.sv
module trap_prio_ctrl_chk #(
  parameter int unsigned N_TRAPS = 8,
  parameter int unsigned PW      = 4,
  parameter int unsigned IW      = 3,
  parameter int unsigned DW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N_TRAPS-1:0] trap_req,
  input logic          insn_done,
  input logic          handler_ret,
  input logic          trap_take,
  input logic [IW-1:0] vec_idx,
  input logic [PW-1:0] pri_out,
  input logic          trap_active,
  input logic          lockout_rst,
  input logic [DW-1:0] depth,
  input logic          multi_evt,
  input logic          ret_evt
);
  // R6: top bit of priority set while a trap runs
  a_r6_bit3_active: assert property (@(posedge clk) disable iff (!rst_n)
    trap_active |-> pri_out[PW-1]);

  // R6: entry level matches the vector
  a_r6_take_level: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> (pri_out == PW'(N_TRAPS) + PW'(vec_idx)) && trap_active);

  // R3: entry only after a completed instruction
  a_r3_take_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> $past(insn_done));

  // R5: nested entry only above running level
  a_r5_preempt_higher: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && $past(trap_active)) |->
      ((PW'(N_TRAPS) + PW'(vec_idx)) > $past(pri_out)));

  // R9: simultaneous requests force lockout
  a_r9_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(trap_req) >= 2) |=> (lockout_rst && !trap_take && !trap_active));

  // R7: return pops one level
  a_r7_ret_pops: assert property (@(posedge clk) disable iff (!rst_n)
    ret_evt |=> (depth == $past(depth) - DW'(1)));

  // R7: return blocks entry in the same cycle
  a_r7_ret_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_ret && trap_active) |=> !trap_take);

  // R10: depth never exceeds the number of levels
  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(N_TRAPS));

  // R9: lockout only after a multi-request cycle
  a_r9_lock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_rst |-> $past(multi_evt));
endmodule

bind trap_prio_ctrl trap_prio_ctrl_chk #(
  .N_TRAPS(N_TRAPS), .PW(PW), .IW(IW), .DW(DW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_req   (trap_req),
  .insn_done  (insn_done),
  .handler_ret(handler_ret),
  .trap_take  (trap_take),
  .vec_idx    (vec_idx),
  .pri_out    (pri_out),
  .trap_active(trap_active),
  .lockout_rst(lockout_rst),
  .depth      (depth),
  .multi_evt  (multi_evt),
  .ret_evt    (ret_evt)
);

// File: tb/trap_prio_ctrl_tb.sv
module trap_prio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] trap_req;
  logic [3:0] cur_pri;
  logic       insn_done, handler_ret;
  logic       trap_take, trap_active, lockout_rst;
  logic [2:0] vec_idx;
  logic [3:0] pri_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  trap_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .cur_pri(cur_pri),
    .insn_done(insn_done), .handler_ret(handler_ret), .trap_take(trap_take),
    .vec_idx(vec_idx), .pri_out(pri_out), .trap_active(trap_active),
    .lockout_rst(lockout_rst)
  );

  // reference model
  logic [7:0] m_pend;
  logic [3:0] m_stk [8];
  int         m_sp;
  logic [3:0] m_pri;
  logic       m_take, m_lock;
  logic [2:0] m_vec;

  function automatic int bits_set(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) if (v[i]) c++;
    return c;
  endfunction

  function automatic int highest(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    m_pend = 0; m_sp = 0; m_pri = 0; m_take = 0; m_lock = 0; m_vec = 0;
  endtask

  task automatic model_clock();
    int h;
    bit ret, tk;
    if (bits_set(trap_req) > 1) begin
      model_reset();
      m_lock = 1;
      return;
    end
    m_lock = 0;
    h = highest(m_pend);
    ret = handler_ret && (m_sp > 0);
    tk = (h >= 0) && insn_done && !ret && ((m_sp == 0) || (h + 8 > int'(m_pri)));
    m_take = tk;
    if (ret) begin
      m_sp--; m_pri = m_stk[m_sp];
    end else if (tk) begin
      m_stk[m_sp] = m_pri; m_sp++;
      m_pri = 4'(h + 8); m_vec = 3'(h);
      m_pend[h] = 1'b0;
    end else if (m_sp == 0) begin
      m_pri = cur_pri;
    end
    m_pend = m_pend | trap_req;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R9 lockout_rst", int'(lockout_rst), int'(m_lock));
    check("R3 trap_take", int'(trap_take), int'(m_take));
    check("R3 vec_idx", int'(vec_idx), int'(m_vec));
    check("R6 pri_out", int'(pri_out), int'(m_pri));
    check("R6 trap_active", int'(trap_active), int'(m_sp > 0));
  endtask

  task automatic step(input logic [7:0] r, input logic d, input logic rt,
                      input logic [3:0] cp);
    trap_req = r; insn_done = d; handler_ret = rt; cur_pri = cp;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; trap_req = 0; cur_pri = 4'd9; insn_done = 1; handler_ret = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 take", int'(trap_take), 0);
    check("R1 pri", int'(pri_out), 0);
    check("R1 active", int'(trap_active), 0);
    check("R1 lock", int'(lockout_rst), 0);
    check("R1 vec", int'(vec_idx), 0);
    rst_n = 1;

    // R8 idle tracking
    step(8'h00, 0, 0, 4'd7);
    check("R8 pri follows cur_pri", int'(pri_out), 7);
    // R2 held while instruction not done
    step(8'h04, 0, 0, 4'd7);
    step(8'h00, 0, 0, 4'd7);
    step(8'h00, 0, 0, 4'd7);
    check("R2 no take before done", int'(trap_take), 0);
    // R4 taken despite priority 7
    step(8'h00, 1, 0, 4'd7);
    check("R4 take at pri 7", int'(trap_take), 1);
    check("R4 vec", int'(vec_idx), 2);
    check("R6 level", int'(pri_out), 10);
    // R5 lower does not preempt
    step(8'h02, 1, 0, 4'd0);
    step(8'h00, 1, 0, 4'd0);
    check("R5 lower blocked", int'(trap_take), 0);
    // R5 higher preempts
    step(8'h20, 1, 0, 4'd0);
    step(8'h00, 1, 0, 4'd0);
    check("R5 higher nests", int'(pri_out), 13);
    // R7 return and take same cycle: return wins
    step(8'h00, 1, 1, 4'd0);
    check("R7 restore", int'(pri_out), 10);
    check("R7 ret blocks take", int'(trap_take), 0);
    step(8'h00, 1, 1, 4'd0);
    check("R7 restore to entry pri", int'(pri_out), 7);
    check("R7 inactive", int'(trap_active), 0);
    step(8'h00, 1, 0, 4'd15);
    check("R4 take at pri 15", int'(pri_out), 9);
    step(8'h00, 0, 1, 4'd3);
    step(8'h00, 0, 1, 4'd3);
    check("R7 ret ignored when idle", int'(pri_out), 3);

    // R10 nesting to full depth
    for (int i = 0; i < 8; i++) begin
      step(8'(1 << i), 0, 0, 4'd1);
      step(8'h00, 1, 0, 4'd1);
    end
    check("R10 depth 8 level", int'(pri_out), 15);
    for (int i = 0; i < 8; i++) step(8'h00, 0, 1, 4'd1);
    check("R10 unwound", int'(pri_out), 1);
    check("R10 inactive", int'(trap_active), 0);

    // R9 lockout
    step(8'h04, 0, 0, 4'd2);
    step(8'h00, 1, 0, 4'd2);
    step(8'h11, 1, 0, 4'd2);
    check("R9 pulse", int'(lockout_rst), 1);
    check("R9 cleared", int'(trap_active), 0);
    step(8'h00, 1, 0, 4'd2);
    check("R9 single pulse", int'(lockout_rst), 0);
    step(8'h00, 1, 0, 4'd2);
    check("R9 pending discarded", int'(trap_take), 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int p = int'($urandom % 100);
      logic [7:0] r = 0;
      if (p >= 70 && p < 97) r[$urandom % 8] = 1'b1;
      else if (p >= 97) begin
        r[$urandom % 4] = 1'b1;
        r[4 + $urandom % 4] = 1'b1;
      end
      step(r, ($urandom % 4) != 0, ($urandom % 6) == 0, 4'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule